// File: doc/BRIEF.md
# Serial Control Register Slave

This block lets an external two-wire bus master set and inspect a small bank of clock-control registers. SCL and SDA are brought into the system clock domain through two-flop synchronisers. START and STOP conditions are detected from the synchronised lines. The block answers one fixed 7-bit device address. SDA is driven through an open-drain enable: the block only ever pulls the line low.

Every write carries a fixed preamble. The address byte is followed by two filler bytes, and the block acknowledges both and throws their contents away. The bytes after them land in register 0, then register 1, and so on until STOP. There is no register pointer. A read streams the registers out from register 0 in index order, right after the address acknowledge, until the master answers a byte with NACK.

The bank has four writable control bytes, each with its own power-up value. Above them sit a read-only byte that holds four strap pins captured during reset, a span of empty read-only slots, and two read-only identification bytes. The writable bytes drive the parallel output bus.

Top module: `ctl_reg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transfer at the address byte from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released and leaves the registers as they were.
- R2: Only address 7'b1101001 is answered: 0xD2 for a write and 0xD3 for a read. Any other address byte gets no ACK, and the block then ignores the bus until the next START.
- R3: After a matching address, each received byte is acknowledged by pulling SDA low for the whole ninth clock.
- R4: The first two bytes after a write address are acknowledged and leave every register unchanged.
- R5: From the third byte on, write bytes are stored in register 0, 1, 2 and onward, in arrival order.
- R6: Every read returns bytes MSB first, starting at register 0 right after the address ACK, and moves one register on for each byte the master ACKs.
- R7: After reset the registers are reg0=0x00, reg1=0xCF, reg2=0xFF and reg3=0xFF. Register i appears on regOut[8i+7:8i]. In reg1, bit 5 turns spread-spectrum on and bit 4 picks the wide (±0.5%, value 1) or narrow (±0.25%, value 0) depth.
- R8: Register 4 reads as {1, strap[3:0], 3'b111}. The strap value is the one held on strapIn while reset was asserted, and later changes on strapIn do not alter it.
- R9: Registers 5 to 10 read 0x00, register 11 reads 0x62 and register 12 reads 0x51. Reads past register 12 return 0xFF.
- R10: Write bytes aimed at register 4 or above are acknowledged and discarded.
- R11: A NACK from the master after a read byte ends the transfer. SDA stays released through any further SCL pulses until the next START.
- R12: The drive on SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; strapIn is captured while it is low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| strapIn | input | 4 | Strap levels captured during reset |
| sdaDrvLow | output | 1 | When high, the pad pulls SDA low |
| regOut | output | 32 | The writable registers, register i at bits 8i+7:8i |

## Verification
An SCL edge on the pin reaches the synchronised copy after two clocks and is acted on at the third. The SDA drive (ACK or a read data bit) therefore settles within about three clocks of SCL falling. A byte written to a register lands within about three clocks of the falling edge that ends its eighth bit. The bench holds every SCL phase for eight clocks, well past that latency. It samples ACKs and read bits halfway through the SCL high phase, and it compares regOut with its register model on every clock between transfers, never while one is in flight.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_RACK,
    ST_SEND,
    ST_SACK
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } kind_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic shiftIn;
    logic loadTx;
    logic shiftOut;
    logic wrByte;
  } strobe_t;

  function automatic logic [7:0] wrDefault(input int i);
    case (i)
      0:       return 8'h00;
      1:       return 8'hCF;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/ctl_reg_ctrl.sv
module ctl_reg_ctrl
  import ctl_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    stb,
  output logic       sdaBit,
  output logic       sdaDrvLow
);

  localparam int SYNC_LEN = 3;
  localparam int BIT_W    = 4;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(7);
  localparam logic [BIT_W-1:0] FULL     = BIT_W'(8);

  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
    end
  end

  logic sclS, sclP, sdaS, sdaP;
  assign sclS = sclPipe[SYNC_LEN-2];
  assign sclP = sclPipe[SYNC_LEN-1];
  assign sdaS = sdaPipe[SYNC_LEN-2];
  assign sdaP = sdaPipe[SYNC_LEN-1];

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;

  phase_t phase, phaseN;
  kind_t  kind, kindN;
  logic [BIT_W-1:0] cnt, cntN;
  logic rw, rwN, mAck, mAckN;

  always_comb begin
    stb    = '0;
    phaseN = phase;
    kindN  = kind;
    cntN   = cnt;
    rwN    = rw;
    mAckN  = mAck;
    if (startSeen) begin
      stb.clrIdx = 1'b1;
      phaseN     = ST_RECV;
      kindN      = K_ADDR;
      cntN       = '0;
    end else if (stopSeen) begin
      phaseN = ST_IDLE;
    end else begin
      case (phase)
        ST_RECV: begin
          if (sclRise && cnt != FULL) begin
            stb.shiftIn = 1'b1;
            cntN        = cnt + 1'b1;
          end
          if (sclFall && cnt == FULL) begin
            if (kind == K_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                rwN    = rxByte[0];
                phaseN = ST_RACK;
              end else begin
                phaseN = ST_IDLE;
              end
            end else begin
              phaseN = ST_RACK;
              if (kind == K_DATA) begin
                stb.wrByte = 1'b1;
                stb.incIdx = 1'b1;
              end
            end
          end
        end
        ST_RACK: begin
          if (sclFall) begin
            cntN = '0;
            if (kind == K_ADDR && rw) begin
              stb.loadTx = 1'b1;
              phaseN     = ST_SEND;
            end else begin
              phaseN = ST_RECV;
              case (kind)
                K_ADDR:  kindN = K_CMD;
                K_CMD:   kindN = K_CNT;
                default: kindN = K_DATA;
              endcase
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (cnt == LAST_BIT) begin
              phaseN = ST_SACK;
              cntN   = '0;
              mAckN  = 1'b0;
            end else begin
              stb.shiftOut = 1'b1;
              cntN         = cnt + 1'b1;
            end
          end
        end
        ST_SACK: begin
          if (sclRise) begin
            mAckN = ~sdaS;
            if (!sdaS) stb.incIdx = 1'b1;
          end
          if (sclFall) begin
            if (mAck) begin
              stb.loadTx = 1'b1;
              phaseN     = ST_SEND;
              cntN       = '0;
            end else begin
              phaseN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      kind  <= K_ADDR;
      cnt   <= '0;
      rw    <= 1'b0;
      mAck  <= 1'b0;
    end else begin
      phase <= phaseN;
      kind  <= kindN;
      cnt   <= cntN;
      rw    <= rwN;
      mAck  <= mAckN;
    end
  end

  assign sdaBit    = sdaS;
  assign sdaDrvLow = (phase == ST_RACK) || (phase == ST_SEND && !txBit);

  // R12
  drv_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclS);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (phase == ST_RECV && cnt == '0 && kind == K_ADDR));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (phase == ST_IDLE && !sdaDrvLow));

endmodule

// File: rtl/ctl_reg_dp.sv
module ctl_reg_dp
  import ctl_reg_pkg::*;
#(
  parameter int         NUM_REGS  = 13,
  parameter int         WR_REGS   = 4,
  parameter int         STRAP_IDX = 4,
  parameter int         STRAP_W   = 4,
  parameter int         STRAP_LSB = 3,
  parameter int         ID_IDX    = 11,
  parameter logic [7:0] ID_HI     = 8'h62,
  parameter logic [7:0] ID_LO     = 8'h51
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic                 sdaBit,
  input  logic [STRAP_W-1:0]   strapIn,
  output logic [7:0]           rxByte,
  output logic                 txBit,
  output logic [8*WR_REGS-1:0] regFlat
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] WR_END  = IDX_W'(WR_REGS);

  logic [IDX_W-1:0]   idx;
  logic [7:0]         rxShift, txShift, readByte, strapByte;
  logic [STRAP_W-1:0] strapLat;
  logic [WR_REGS-1:0] wrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapLat <= strapIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (stb.clrIdx) begin
      idx <= '0;
    end else if (stb.incIdx && idx != IDX_END) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
  end
  assign rxByte = rxShift;

  for (genvar g = 0; g < WR_REGS; g++) begin : gHit
    assign wrHit[g] = stb.wrByte && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WR_REGS; i++) regFlat[i*8 +: 8] <= wrDefault(i);
    end else begin
      for (int i = 0; i < WR_REGS; i++)
        if (wrHit[i]) regFlat[i*8 +: 8] <= rxShift;
    end
  end

  always_comb begin
    strapByte = '1;
    strapByte[STRAP_LSB +: STRAP_W] = strapLat;
  end

  always_comb begin
    if (idx < WR_END) begin
      readByte = '0;
      for (int i = 0; i < WR_REGS; i++)
        if (idx == IDX_W'(i)) readByte = regFlat[i*8 +: 8];
    end else if (idx == IDX_W'(STRAP_IDX)) begin
      readByte = strapByte;
    end else if (idx == IDX_W'(ID_IDX)) begin
      readByte = ID_HI;
    end else if (idx == IDX_W'(ID_IDX + 1)) begin
      readByte = ID_LO;
    end else if (idx < IDX_END) begin
      readByte = 8'h00;
    end else begin
      readByte = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '1;
    else if (stb.loadTx)   txShift <= readByte;
    else if (stb.shiftOut) txShift <= {txShift[6:0], 1'b1};
  end
  assign txBit = txShift[7];

  // R10
  ro_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrByte && idx >= WR_END) |=> $stable(regFlat));

  // R6
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrIdx |=> idx == '0);

  // R9
  idx_hold_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incIdx && !stb.clrIdx && idx == IDX_END) |=> idx == IDX_END);

endmodule

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave
  import ctl_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         WR_REGS  = 4,
  parameter int         STRAP_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [STRAP_W-1:0]   strapIn,
  output logic                 sdaDrvLow,
  output logic [8*WR_REGS-1:0] regOut
);

  strobe_t    stb;
  logic       sdaBit, txBit;
  logic [7:0] rxByte;

  ctl_reg_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .stb      (stb),
    .sdaBit   (sdaBit),
    .sdaDrvLow(sdaDrvLow)
  );

  ctl_reg_dp #(
    .WR_REGS(WR_REGS),
    .STRAP_W(STRAP_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .sdaBit (sdaBit),
    .strapIn(strapIn),
    .rxByte (rxByte),
    .txBit  (txBit),
    .regFlat(regOut)
  );

endmodule

// File: tb/ctl_reg_slave_test.sv
module ctl_reg_slave_test;

  localparam int PERIOD = 10;
  localparam int Q      = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic [3:0] strapAtReset = 4'b1010;
  wire        sdaDrvLow;
  wire [31:0] regOut;
  wire        sdaBus = sdaM & ~sdaDrvLow;

  int total = 0;
  int bad = 0;
  logic cmpOn = 1'b0;
  logic [7:0] model [4];
  logic sclLast = 1'b1;
  logic drvLast = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ctl_reg_slave uut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclM),
    .sdaIn    (sdaBus),
    .strapIn  (strap),
    .sdaDrvLow(sdaDrvLow),
    .regOut   (regOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelFlat();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  function automatic logic [7:0] expRead(input int k);
    if (k < 4) return model[k];
    if (k == 4) return {1'b1, strapAtReset, 3'b111};
    if (k < 11) return 8'h00;
    if (k == 11) return 8'h62;
    if (k == 12) return 8'h51;
    return 8'hFF;
  endfunction

  always @(negedge clk) begin
    #(PERIOD/4);
    if (rstN && cmpOn) begin
      chk(regOut == modelFlat(), "R4 R5 R10 register image", regOut, modelFlat());
      chk(!sdaDrvLow, "R11 idle bus released", {31'd0, sdaDrvLow}, 32'd0);
    end
    if (rstN && sclM && sclLast)
      chk(sdaDrvLow == drvLast, "R12 drive steady while SCL high", {31'd0, sdaDrvLow}, {31'd0, drvLast});
    sclLast = sclM;
    drvLast = sdaDrvLow;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; wt(Q);
    sclM = 1'b1; wt(Q);
    sdaM = 1'b0; wt(Q);
    sclM = 1'b0; wt(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; wt(Q);
    sclM = 1'b1; wt(Q);
    sdaM = 1'b1; wt(Q);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b;    wt(Q);
    sclM = 1'b1; wt(Q);
    sclM = 1'b0; wt(Q);
  endtask

  task automatic byteOut(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    sdaM = 1'b1; wt(Q);
    sclM = 1'b1; wt(Q/2);
    ack = !sdaBus;
    wt(Q/2);
    sclM = 1'b0; wt(Q);
  endtask

  task automatic byteIn(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      sclM = 1'b1; wt(Q/2);
      b[i] = sdaBus;
      wt(Q/2);
      sclM = 1'b0;
    end
    wt(1);
    sdaM = !giveAck; wt(Q);
    sclM = 1'b1;     wt(Q);
    sclM = 1'b0;     wt(Q);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] d [$]);
    bit ack;
    cmpOn = 1'b0;
    startC();
    byteOut(8'hD2, ack);
    chk(ack, "R2 write address acknowledged", {31'd0, ack}, 32'd1);
    byteOut(8'hA5, ack);
    chk(ack, "R3 R4 command filler acknowledged", {31'd0, ack}, 32'd1);
    byteOut(8'h3C, ack);
    chk(ack, "R3 R4 count filler acknowledged", {31'd0, ack}, 32'd1);
    foreach (d[k]) begin
      byteOut(d[k], ack);
      chk(ack, "R3 R10 data byte acknowledged", {31'd0, ack}, 32'd1);
      if (k < 4) model[k] = d[k];
    end
    stopC();
    wt(4);
    cmpOn = 1'b1;
  endtask

  task automatic doRead(input int n);
    bit ack;
    logic [7:0] b;
    cmpOn = 1'b0;
    startC();
    byteOut(8'hD3, ack);
    chk(ack, "R2 read address acknowledged", {31'd0, ack}, 32'd1);
    for (int k = 0; k < n; k++) begin
      byteIn(k != n - 1, b);
      if (k == 4)     chk(b == expRead(k), "R8 strap register", {24'd0, b}, {24'd0, expRead(k)});
      else if (k > 4) chk(b == expRead(k), "R9 read-only span", {24'd0, b}, {24'd0, expRead(k)});
      else            chk(b == expRead(k), "R6 sequential read", {24'd0, b}, {24'd0, expRead(k)});
    end
    stopC();
    wt(4);
    cmpOn = 1'b1;
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    model[0] = 8'h00; model[1] = 8'hCF; model[2] = 8'hFF; model[3] = 8'hFF;
    wt(5);
    rstN = 1'b1;
    wt(5);
    chk(regOut == 32'hFFFF_CF00, "R7 reset defaults", regOut, 32'hFFFF_CF00);
    chk(!sdaDrvLow, "R7 released after reset", {31'd0, sdaDrvLow}, 32'd0);
    strap = 4'b0101;
    cmpOn = 1'b1;

    // R4: fillers only
    doWrite('{});
    chk(regOut == 32'hFFFF_CF00, "R4 fillers leave registers", regOut, 32'hFFFF_CF00);

    // R5 and R10: data to 0..3 then discarded
    doWrite('{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC});
    chk(regOut == 32'h7856_3412, "R5 in-order stores", regOut, 32'h7856_3412);

    // R6 R8 R9 full sweep, then R11 after NACK
    cmpOn = 1'b0;
    startC();
    byteOut(8'hD3, ack);
    chk(ack, "R2 read address acknowledged", {31'd0, ack}, 32'd1);
    for (int k = 0; k < 15; k++) begin
      byteIn(k != 14, b);
      if (k == 4)     chk(b == expRead(k), "R8 strap register", {24'd0, b}, {24'd0, expRead(k)});
      else if (k > 4) chk(b == expRead(k), "R9 read-only span", {24'd0, b}, {24'd0, expRead(k)});
      else            chk(b == expRead(k), "R6 sequential read", {24'd0, b}, {24'd0, expRead(k)});
    end
    byteOut(8'hFF, ack);
    chk(!ack, "R11 no drive after NACK", {31'd0, ack}, 32'd0);
    stopC();
    wt(4);
    cmpOn = 1'b1;

    // R2: foreign addresses
    cmpOn = 1'b0;
    startC();
    byteOut(8'hA0, ack);
    chk(!ack, "R2 foreign address ignored", {31'd0, ack}, 32'd0);
    byteOut(8'h11, ack);
    chk(!ack, "R2 bytes after foreign address", {31'd0, ack}, 32'd0);
    stopC();
    startC();
    byteOut(8'hD5, ack);
    chk(!ack, "R2 foreign read address ignored", {31'd0, ack}, 32'd0);
    stopC();
    wt(4);
    cmpOn = 1'b1;

    // R6: each read restarts at register 0
    doRead(2);
    doRead(3);

    // R1: STOP in the middle of a data byte
    cmpOn = 1'b0;
    startC();
    byteOut(8'hD2, ack);
    byteOut(8'h00, ack);
    byteOut(8'h00, ack);
    bitOut(1'b1); bitOut(1'b0); bitOut(1'b1); bitOut(1'b0);
    stopC();
    wt(4);
    chk(regOut == 32'h7856_3412, "R1 partial byte dropped on STOP", regOut, 32'h7856_3412);
    chk(!sdaDrvLow, "R1 released on STOP", {31'd0, sdaDrvLow}, 32'd0);
    cmpOn = 1'b1;

    // R1: repeated START switches a write into a read
    cmpOn = 1'b0;
    startC();
    byteOut(8'hD2, ack);
    byteOut(8'h77, ack);
    startC();
    byteOut(8'hD3, ack);
    chk(ack, "R1 repeated start readdressed", {31'd0, ack}, 32'd1);
    byteIn(1'b0, b);
    chk(b == 8'h12, "R1 read after repeated start", {24'd0, b}, 32'h12);
    stopC();
    wt(4);
    cmpOn = 1'b1;

    // R7: spread fields in register 1
    doWrite('{8'h5A, 8'h30});
    chk(regOut[13:12] == 2'b11, "R7 spread enable and wide depth", {30'd0, regOut[13:12]}, 32'd3);
    doRead(5);

    wt(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule